// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets any core of a multicore system post a short message to any other core and raise that core's interrupt line. Each core owns a pair of 32-bit registers on a word-addressed register bus. One is a command word. The core writes it to send a message or to acknowledge the message it holds. The other is a status word. It shows whether a message is waiting, which core sent it, and the 16-bit payload.

A delivered message stays latched in the receiver's status word. The receiver's interrupt output is a level signal that stays high until the receiver acknowledges. The block takes no interrupt inputs; all traffic arrives as bus writes. The core count is a parameter. Register words are presented with the bit numbering below and no byte lane swapping.

The bus uses plain strobes with no back-pressure. A write completes in the cycle its strobe is high. Read data appears one cycle after the read strobe and is zero in every other cycle.

Top module: `ipi_mailbox`

## Requirements
- R1: Reset clears every pending flag, source field and payload field, so every interrupt output is low and every status word reads 0.
- R2: Bus word address 2n selects core n's command word and word address 2n+1 selects its status word (byte offsets 8n and 8n+4). The core that writes word 2n is taken as the sender or the acknowledger.
- R3: A status read returns 0 in bit 31, the pending flag in bit 30, the sender index zero-extended in bits 29..16 and the payload in bits 15..0. The value appears on bus_rdata in the cycle after bus_rd, and bus_rdata is 0 in any cycle not preceded by a read.
- R4: A command write with bit 30 (send) set delivers to the core indexed by bits 29..16. That core's pending flag is set, its source field is loaded with the writer's index, and its payload field is loaded with bits 15..0.
- R5: irq_o[n] equals core n's pending flag. It stays high from delivery until core n acknowledges.
- R6: A command write with bit 31 (acknowledge) set clears the writer's own pending flag and leaves its source and payload fields unchanged.
- R7: When acknowledge and send are set in one write, the acknowledge is applied first and the delivery second. A core that sends to itself this way ends with its pending flag set.
- R8: A delivery to a core that is already pending replaces its source and payload, and the flag stays set.
- R9: A command write with send set and a destination index at or above the core count is discarded as a whole, including any acknowledge in the same word.
- R10: Reading a command word returns 0, and writes to a status word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address (two words per core) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_o | output | NUM_CORES | Level interrupt per core |

## Verification
The delicate collision is an acknowledge and a delivery landing on the same pending flag in the same clock. This happens when a core sends to itself with both command bits set, and when a pending core acknowledges while sending elsewhere. A second collision is a fresh delivery arriving at a core that is still pending. Directed writes provoke each case, and a long run of random writes and reads with destinations that are often out of range or equal to the sender repeats them. A behavioural model in the bench judges every interrupt line on every clock and every status read word.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CMD_ACK_BIT = 31;
  localparam int CMD_SEND_BIT = 30;
  localparam int DST_HI = 29;
  localparam int DST_LO = 16;
  localparam int IDX_FIELD_W = DST_HI - DST_LO + 1;
  localparam int PAYLOAD_W = 16;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic                   rsvd;
    logic                   pend;
    logic [IDX_FIELD_W-1:0] src;
    logic [PAYLOAD_W-1:0]   payload;
  } stat_word_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SRC_W = 2,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [NUM_CORES-1:0] ack_vec,
  output logic [NUM_CORES-1:0] dlv_vec,
  output logic [SRC_W-1:0]     writer_idx,
  output logic [PAYLOAD_W-1:0] payload
);
  logic                   is_cmd;
  logic                   dst_ok;
  logic                   accept;
  logic [IDX_FIELD_W-1:0] dst;

  assign writer_idx = addr[ADDR_W-1:1];
  assign dst        = wdata[DST_HI:DST_LO];
  assign payload    = wdata[PAYLOAD_W-1:0];
  assign is_cmd     = wr_en && !addr[0] && (32'(writer_idx) < NUM_CORES);
  assign dst_ok     = 32'(dst) < NUM_CORES;
  // a send to a nonexistent core voids the whole word
  assign accept     = is_cmd && !(wdata[CMD_SEND_BIT] && !dst_ok);

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++) begin
      ack_vec[i] = accept && wdata[CMD_ACK_BIT] && (32'(writer_idx) == i);
      dlv_vec[i] = accept && wdata[CMD_SEND_BIT] && (32'(dst) == i);
    end
  end

  // R9: a bad destination leaves every slot untouched
  a_r9_bad_dst_void: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr[0] && wdata[CMD_SEND_BIT] && (32'(wdata[DST_HI:DST_LO]) >= NUM_CORES))
    |-> (ack_vec == '0 && dlv_vec == '0));
  // R10: status-word writes produce no command
  a_r10_stat_wr_void: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[0] || !wr_en) |-> (ack_vec == '0 && dlv_vec == '0));
  // R6: only the writer can be acknowledged
  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec));
  // R4: one destination per write
  a_r4_dlv_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dlv_vec));
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
#(
  parameter int SRC_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dlv,
  input  logic                 ack,
  input  logic [SRC_W-1:0]     src_in,
  input  logic [PAYLOAD_W-1:0] data_in,
  output logic                 pend_q,
  output logic [SRC_W-1:0]     src_q,
  output logic [PAYLOAD_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      src_q  <= '0;
      data_q <= '0;
    end else if (dlv) begin
      // acknowledge is applied first, so delivery wins the flag
      pend_q <= 1'b1;
      src_q  <= src_in;
      data_q <= data_in;
    end else if (ack) begin
      pend_q <= 1'b0;
    end
  end

  a_r4_deliver: assert property (@(posedge clk) disable iff (!rst_n)
    dlv |=> (pend_q && src_q == $past(src_in) && data_q == $past(data_in)));
  a_r6_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !dlv) |=> !pend_q);
  a_r7_ack_then_send: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && dlv) |=> pend_q);
  a_r5_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !dlv) |=> !pend_q);
  a_r6_fields_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv |=> ($stable(src_q) && $stable(data_q)));
endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SRC_W = 2,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_CORES-1:0] pend_vec,
  input  logic [SRC_W-1:0]     src_arr  [NUM_CORES],
  input  logic [PAYLOAD_W-1:0] data_arr [NUM_CORES],
  output logic [WORD_W-1:0]    rdata
);
  logic [SRC_W-1:0] sel;
  logic             stat_hit;
  stat_word_t       word_d;

  assign sel      = addr[ADDR_W-1:1];
  assign stat_hit = rd_en && addr[0] && (32'(sel) < NUM_CORES);

  always_comb begin
    word_d = '0;
    if (stat_hit) begin
      word_d.pend    = pend_vec[sel];
      word_d.src     = IDX_FIELD_W'(src_arr[sel]);
      word_d.payload = data_arr[sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= word_d;
  end

  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[WORD_W-1]);
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
  a_r10_cmd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !addr[0]) |=> (rdata == '0));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int SRC_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W = SRC_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_CORES-1:0] irq_o
);
  logic [NUM_CORES-1:0] ack_vec;
  logic [NUM_CORES-1:0] dlv_vec;
  logic [NUM_CORES-1:0] pend_vec;
  logic [SRC_W-1:0]     writer_idx;
  logic [PAYLOAD_W-1:0] payload;
  logic [SRC_W-1:0]     src_arr  [NUM_CORES];
  logic [PAYLOAD_W-1:0] data_arr [NUM_CORES];

  ipi_cmd_decode #(
    .NUM_CORES(NUM_CORES), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .ack_vec(ack_vec), .dlv_vec(dlv_vec),
    .writer_idx(writer_idx), .payload(payload)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    ipi_slot #(.SRC_W(SRC_W)) slot_i (
      .clk(clk), .rst_n(rst_n), .dlv(dlv_vec[g]), .ack(ack_vec[g]),
      .src_in(writer_idx), .data_in(payload), .pend_q(pend_vec[g]),
      .src_q(src_arr[g]), .data_q(data_arr[g])
    );
  end

  ipi_read_port #(
    .NUM_CORES(NUM_CORES), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) rdp_i (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr),
    .pend_vec(pend_vec), .src_arr(src_arr), .data_arr(data_arr),
    .rdata(bus_rdata)
  );

  assign irq_o = pend_vec;

  // R1: first cycle out of reset has every line low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0));
endmodule

// File: tb/ipi_mailbox_tb_top.sv
module ipi_mailbox_tb_top;
  localparam int N = 4;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_o;

  ipi_mailbox #(.NUM_CORES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic rd_seen = 1'b0;

  // behavioural reference state
  logic [N-1:0] m_pend = '0;
  int           m_src [N];
  logic [15:0]  m_dat [N];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status(int core);
    logic [13:0] s;
    s = 14'(m_src[core]);
    return {1'b0, m_pend[core], s, m_dat[core]};
  endfunction

  // reference write: status words ignored, bad destination voids the word,
  // acknowledge before delivery
  function automatic void m_write(int a, logic [31:0] d);
    int core = a / 2;
    int dst = int'(d[29:16]);
    if (a % 2 == 1) return;
    if (d[30] && dst >= N) return;
    if (d[31]) m_pend[core] = 1'b0;
    if (d[30]) begin
      m_pend[dst] = 1'b1;
      m_src[dst]  = core;
      m_dat[dst]  = d[15:0];
    end
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    m_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, string req, logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic rd_model(int a, string req);
    logic [31:0] e;
    e = (a % 2 == 1) ? m_status(a / 2) : 32'h0;
    rd(a, req, e);
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // every-clock comparison of the interrupt lines (R5) and idle read data (R3)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 irq_o", 32'(irq_o), 32'(m_pend));
      if (!rd_seen) chk("R3 idle rdata", bus_rdata, 32'h0);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_src[i] = 0; m_dat[i] = '0; end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: everything cleared
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    for (int i = 0; i < N; i++) rd(2 * i + 1, "R1 status after reset", 32'h0);

    // R4, R2: core 0 (word 0) sends 0xBEEF to core 2 (status at word 5)
    wr(0, 32'h4002_BEEF);
    rd(5, "R4 delivery", 32'h4000_BEEF);
    // R8: core 1 (word 2) overwrites while core 2 pending
    wr(2, 32'h4002_1234);
    rd(5, "R8 overwrite", 32'h4001_1234);
    // R6: core 2 acknowledges, fields kept
    wr(4, 32'h8000_0000);
    rd(5, "R6 ack clears pending", 32'h0001_1234);
    chk("R6 irq line dropped", 32'(irq_o[2]), 32'h0);
    // R7: core 3 sends to itself with acknowledge set too
    wr(6, 32'hC003_00AA);
    rd(7, "R7 self send", 32'h4003_00AA);
    // R7: pending core 1 acknowledges and sends to core 0 in one word
    wr(4, 32'h4001_0055);
    rd(3, "R4 core2 to core1", 32'h4002_0055);
    wr(2, 32'hC000_0077);
    rd(3, "R7 writer cleared", 32'h0002_0055);
    rd(1, "R7 destination set", 32'h4001_0077);
    // R9: out-of-range destinations void the word, acknowledge included
    wr(6, 32'hC004_0999);
    rd(7, "R9 dst=count ignored", 32'h4003_00AA);
    wr(0, 32'hFFFF_0001);
    rd(1, "R9 dst=max ignored", 32'h4001_0077);
    // R10: command reads zero, status writes dropped
    rd(0, "R10 command read", 32'h0);
    rd(6, "R10 command read", 32'h0);
    wr(1, 32'h4002_FFFF);
    wr(3, 32'hC000_0000);
    rd(1, "R10 status write ignored", 32'h4001_0077);
    rd(3, "R10 status write ignored", 32'h0002_0055);
    // R6: acknowledge with nothing pending is harmless
    wr(2, 32'h8000_0000);
    rd(3, "R6 idle ack", 32'h0002_0055);

    // random mix checked against the model
    for (int k = 0; k < 600; k++) begin
      int a = int'($urandom_range(0, 2 * N - 1));
      if ($urandom_range(0, 2) == 0) begin
        rd_model(a, "R3 random read");
      end else begin
        logic [31:0] d;
        d = $urandom;
        d[29:16] = ($urandom_range(0, 7) == 0) ? 14'h3FFF : 14'($urandom_range(0, N + 1));
        wr(a, d);
      end
    end
    for (int i = 0; i < N; i++) rd_model(2 * i + 1, "R3 final status");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule